// File: doc/BRIEF.md
# HDLC serial receive channel

This block receives a synchronous HDLC bit stream on its own line clock. It finds the 0x7E flags that delimit frames and removes the zero the transmitter inserts after five ones. It detects the seven-ones abort and assembles the remaining bits, least significant bit first, into bytes. It also checks the frame check sequence against the standard residue. Data bytes go to a backend one at a time over a valid/take handshake. The trailing FCS bytes are consumed inside the block and are never offered to the backend.

The block has no configuration registers. Its status is four frame signals. `frame_active` is high while a frame is being received. `frame_done` pulses when a frame closes cleanly. `frame_err` flags a frame that is misaligned, fails the FCS check, or loses a byte because the backend was too slow. `frame_abort` pulses when an abort is seen. `rx_en` gates the line so that the channel can sit on a shared bus. The CRC is chosen at elaboration time: CRC-16 (two FCS bytes) or CRC-32 (four FCS bytes).

A single state machine controls frame sequencing. Its states are:
- HUNT: waiting for a flag after reset or an abort.
- SYNC: a flag has been seen and no data has arrived yet.
- DATA: the frame is being received.
- DROP: the frame is being discarded after a missed byte.
- GOOD: one-cycle clean close.
- BAD: one-cycle failed close.
- ABORT: one-cycle abort report.

Its transitions are:
- HUNT→SYNC on a flag.
- SYNC→SYNC on a repeated flag.
- SYNC→DATA on the first data bit.
- SYNC→HUNT on an abort.
- DATA→GOOD on a closing flag with a good check.
- DATA→BAD on a closing flag with a failed check.
- DATA→DROP on a take timeout.
- DATA→ABORT and DROP→ABORT on an abort.
- DROP→SYNC on a flag.
- GOOD→SYNC and BAD→SYNC.
- ABORT→HUNT.

Top module: `hdlc_rx_channel`

## Requirements
- R1: The flag is the bit pattern 0,1,1,1,1,1,1,0. A flag in HUNT opens the channel. Consecutive flags with no data between them cause no frame activity: `frame_active` stays low. One flag can close one frame and open the next.
- R2: Inside a frame, a 0 received right after five consecutive 1s is discarded, so data bytes that contain runs of ones (such as 0xFF and 0x7E) arrive unchanged.
- R3: Seven consecutive 1s form an abort. During a frame, an abort gives a one-cycle `frame_abort` with no `frame_done` and no `frame_err`, and withdraws any byte still offered. No further frame is received until a new flag arrives.
- R4: Bits are assembled least significant bit first. Each data byte is presented on `out_data` with `out_valid` high and is held stable until `byte_take` is sampled high. The final FCS bytes (2 for CRC-16, 4 for CRC-32) are never presented.
- R5: A frame that closes byte aligned and has a correct FCS gives a one-cycle `frame_done`. The FCS is checked over all frame bits, FCS included, for the residue. CRC-16 (`FCS32`=0) uses the reflected polynomial 0x8408, an all-ones start value and residue 0xF0B8. CRC-32 (`FCS32`=1) uses 0xEDB88320 and residue 0xDEBB20E3. The FCS is sent complemented, low bit first.
- R6: A frame that closes with a bit count that is not a multiple of 8, or with fewer bytes than the FCS length, gives `frame_err` for one cycle together with `frame_active`, and no `frame_done`.
- R7: A frame that closes aligned with a wrong FCS gives `frame_err` for one cycle together with `frame_active`, and no `frame_done`.
- R8: If an offered byte is not taken within `TAKE_WINDOW` clock cycles while the frame is being received, `frame_err` rises. It stays high together with `frame_active` until the closing flag or an abort. No further bytes of that frame are offered, and no `frame_done` follows.
- R9: While `rx_en` is low, `rx_bit` is ignored and bit reception is frozen.
- R10: After reset all outputs are low. `frame_err` is never high without `frame_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; one bit per cycle when enabled |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; the bit is used only when high |
| rx_bit | input | 1 | Serial line data |
| out_data | output | 8 | Offered data byte |
| out_valid | output | 1 | A byte is offered on `out_data` |
| byte_take | input | 1 | Backend takes the offered byte this cycle |
| frame_active | output | 1 | A frame is being received |
| frame_err | output | 1 | Frame error: misaligned, FCS failure or missed byte |
| frame_done | output | 1 | One-cycle pulse on a clean close |
| frame_abort | output | 1 | One-cycle pulse on an abort during a frame |

## Verification
The assertions assume that `TAKE_WINDOW` is at most 7. With that limit, a held byte times out before the next byte could be released and overwrite it. They also assume that the backend asserts `byte_take` only while `out_valid` is high.

The bench changes `rx_bit` and `rx_en` only on falling edges. It raises `byte_take` for one cycle per offered byte, except in the slow-backend scenario, where it never takes. The stimulus never puts a flag inside the bits that follow an abort. It inserts disabled cycles only between bits, never within the six-bit lookahead in a way that would alter a pattern.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [2:0] {
        S_HUNT,
        S_SYNC,
        S_DATA,
        S_DROP,
        S_GOOD,
        S_BAD,
        S_ABORT
    } rx_state_t;

    typedef struct packed {
        logic flag;
        logic abort;
        logic dvalid;
        logic dbit;
    } line_ev_t;

endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
    import hdlc_rx_pkg::*;
#(
    parameter int LOOKAHEAD = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     bit_in,
    output line_ev_t ev
);
    localparam int CW = $clog2(LOOKAHEAD + 1);

    logic [2:0]           ones;
    logic [LOOKAHEAD-1:0] dly;
    logic [CW-1:0]        dcnt;
    logic                 is_flag;
    logic                 is_abort;
    logic                 stuffed;
    logic                 held_one;
    logic                 emit;

    always_comb begin
        is_flag  = en && !bit_in && (ones == 3'd6);
        is_abort = en && bit_in && (ones == 3'd6);
        stuffed  = !bit_in && (ones == 3'd5);
        held_one = bit_in && (ones >= 3'd5);
        emit     = en && !is_flag && !stuffed && !held_one;
        ev.flag   = is_flag;
        ev.abort  = is_abort;
        ev.dvalid = emit && (dcnt == CW'(LOOKAHEAD));
        ev.dbit   = dly[LOOKAHEAD-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones <= 3'd0;
            dly  <= '0;
            dcnt <= '0;
        end else if (en) begin
            if (bit_in) begin
                if (ones != 3'd7) ones <= ones + 3'd1;
            end else begin
                ones <= 3'd0;
            end
            if (is_flag || is_abort) begin
                dcnt <= '0;
            end else if (emit) begin
                dly <= {dly[LOOKAHEAD-2:0], bit_in};
                if (dcnt != CW'(LOOKAHEAD)) dcnt <= dcnt + CW'(1);
            end
        end
    end

    p_flag_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev.flag |=> !ev.flag);

    p_abort_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev.abort |=> !ev.flag);

endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs #(
    parameter bit FCS32 = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bit_in,
    output logic match
);
    localparam int W = FCS32 ? 32 : 16;
    localparam logic [W-1:0] POLY  = W'(FCS32 ? 32'hEDB8_8320 : 32'h0000_8408);
    localparam logic [W-1:0] RESID = W'(FCS32 ? 32'hDEBB_20E3 : 32'h0000_F0B8);

    logic [W-1:0] crc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '1;
        end else if (clr) begin
            crc <= '1;
        end else if (en) begin
            crc <= (crc >> 1) ^ ((crc[0] ^ bit_in) ? POLY : '0);
        end
    end

    assign match = (crc == RESID);

endmodule

// File: rtl/hdlc_rx_bytes.sv
module hdlc_rx_bytes #(
    parameter int FCS_BYTES   = 2,
    parameter int TAKE_WINDOW = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       dvalid,
    input  logic       dbit,
    input  logic       release_en,
    input  logic       flush,
    input  logic       win_run,
    input  logic       byte_take,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       aligned,
    output logic       timeout
);
    localparam int FW = $clog2(FCS_BYTES + 1);
    localparam int WW = $clog2(TAKE_WINDOW + 1);

    logic [2:0]    bitcnt;
    logic [7:0]    sr;
    logic [7:0]    new_byte;
    logic [7:0]    hold [FCS_BYTES];
    logic [FW-1:0] fill;
    logic [WW-1:0] wcnt;
    logic          byte_done;
    logic          pipe_full;
    logic          rel;

    always_comb begin
        new_byte  = {dbit, sr[7:1]};
        byte_done = dvalid && (bitcnt == 3'd7);
        pipe_full = (fill == FW'(FCS_BYTES));
        rel       = byte_done && pipe_full && release_en && !clr;
        aligned   = (bitcnt == 3'd0) && pipe_full;
        timeout   = win_run && out_valid && !byte_take && (wcnt == WW'(TAKE_WINDOW - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= 3'd0;
            sr     <= 8'd0;
            fill   <= '0;
        end else if (clr) begin
            bitcnt <= 3'd0;
            fill   <= '0;
        end else if (dvalid) begin
            sr     <= new_byte;
            bitcnt <= bitcnt + 3'd1;
            if (byte_done && !pipe_full) fill <= fill + FW'(1);
        end
    end

    for (genvar i = 0; i < FCS_BYTES; i++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold[i] <= 8'd0;
            end else if (byte_done && !clr) begin
                if (i == 0) hold[i] <= new_byte;
                else        hold[i] <= hold[(i == 0) ? 0 : i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'd0;
            wcnt      <= '0;
        end else begin
            if (flush) begin
                out_valid <= 1'b0;
            end else if (rel) begin
                out_valid <= 1'b1;
                out_data  <= hold[FCS_BYTES-1];
            end else if (byte_take) begin
                out_valid <= 1'b0;
            end
            if (rel || !out_valid) begin
                wcnt <= '0;
            end else if (win_run && !byte_take && wcnt != WW'(TAKE_WINDOW)) begin
                wcnt <= wcnt + WW'(1);
            end
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !byte_take && !flush) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/hdlc_rx_channel.sv
module hdlc_rx_channel
    import hdlc_rx_pkg::*;
#(
    parameter bit FCS32       = 1'b0,
    parameter int TAKE_WINDOW = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       rx_bit,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       byte_take,
    output logic       frame_active,
    output logic       frame_err,
    output logic       frame_done,
    output logic       frame_abort
);
    localparam int FCS_BYTES = FCS32 ? 4 : 2;

    rx_state_t state, state_nx;
    line_ev_t  ev;
    logic      crc_ok;
    logic      aligned;
    logic      timeout;
    logic      clr;
    logic      release_en;
    logic      flush;

    hdlc_rx_line #(.LOOKAHEAD(6)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rx_en),
        .bit_in (rx_bit),
        .ev     (ev)
    );

    assign clr = ev.flag || ev.abort;

    hdlc_rx_fcs #(.FCS32(FCS32)) u_fcs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (ev.dvalid),
        .bit_in (ev.dbit),
        .match  (crc_ok)
    );

    hdlc_rx_bytes #(.FCS_BYTES(FCS_BYTES), .TAKE_WINDOW(TAKE_WINDOW)) u_bytes (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .dvalid     (ev.dvalid),
        .dbit       (ev.dbit),
        .release_en (release_en),
        .flush      (flush),
        .win_run    (state == S_DATA),
        .byte_take  (byte_take),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .aligned    (aligned),
        .timeout    (timeout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_HUNT:  if (ev.flag) state_nx = S_SYNC;
            S_SYNC: begin
                if (ev.abort)       state_nx = S_HUNT;
                else if (ev.dvalid) state_nx = S_DATA;
            end
            S_DATA: begin
                if (ev.abort)     state_nx = S_ABORT;
                else if (ev.flag) state_nx = (aligned && crc_ok) ? S_GOOD : S_BAD;
                else if (timeout) state_nx = S_DROP;
            end
            S_DROP: begin
                if (ev.abort)     state_nx = S_ABORT;
                else if (ev.flag) state_nx = S_SYNC;
            end
            S_GOOD, S_BAD: state_nx = ev.abort ? S_HUNT : S_SYNC;
            S_ABORT:       state_nx = S_HUNT;
            default:       state_nx = S_HUNT;
        endcase
    end

    always_comb begin
        frame_active = 1'b0;
        frame_err    = 1'b0;
        frame_done   = 1'b0;
        frame_abort  = 1'b0;
        release_en   = 1'b0;
        flush        = 1'b0;
        unique case (state)
            S_HUNT:  flush = 1'b1;
            S_SYNC:  ;
            S_DATA: begin
                frame_active = 1'b1;
                release_en   = 1'b1;
            end
            S_DROP: begin
                frame_active = 1'b1;
                frame_err    = 1'b1;
                flush        = 1'b1;
            end
            S_GOOD: begin
                frame_active = 1'b1;
                frame_done   = 1'b1;
            end
            S_BAD: begin
                frame_active = 1'b1;
                frame_err    = 1'b1;
            end
            S_ABORT: begin
                frame_abort = 1'b1;
                flush       = 1'b1;
            end
            default: flush = 1'b1;
        endcase
    end

    p_err_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> frame_active);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_abort_withdraws_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |=> !out_valid);

    p_drop_no_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP) |=> !$rose(out_valid));

    p_idle_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && (state == S_HUNT || state == S_SYNC)) |=> $stable(state));

endmodule

// File: tb/tb_hdlc_rx_channel.sv
module tb_hdlc_rx_channel;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic       byte_take = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       frame_active, frame_err, frame_done, frame_abort;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_channel #(.FCS32(1'b0), .TAKE_WINDOW(6)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
        .out_data(out_data), .out_valid(out_valid), .byte_take(byte_take),
        .frame_active(frame_active), .frame_err(frame_err),
        .frame_done(frame_done), .frame_abort(frame_abort)
    );

    int n_chk = 0;
    int n_fail = 0;

    // monitor state (written only by the monitor)
    logic       take_en = 1'b1;
    logic [7:0] got [0:255];
    int         ngot = 0, n_done = 0, n_err_rise = 0, n_abort = 0, n_active = 0, n_bad_err = 0;
    logic       prev_err = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && take_en && !byte_take) begin
                byte_take <= 1'b1;
                if (ngot < 256) got[ngot] = out_data;
                ngot = ngot + 1;
            end else begin
                byte_take <= 1'b0;
            end
            if (frame_done) n_done = n_done + 1;
            if (frame_abort) n_abort = n_abort + 1;
            if (frame_active) n_active = n_active + 1;
            if (frame_err && !prev_err) n_err_rise = n_err_rise + 1;
            if (frame_err && !frame_active) n_bad_err = n_bad_err + 1;
            prev_err = frame_err;
        end
    end

    // stimulus state
    int         ones_run = 0;
    logic [15:0] crc = 16'hFFFF;
    logic [7:0] exp_b [0:7];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        rx_en  = 1'b1;
        rx_bit = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_en  = 1'b0;
            rx_bit = 1'b1;
        end
    endtask

    task automatic send_flag();
        put_bit(1'b0);
        for (int i = 0; i < 6; i++) put_bit(1'b1);
        put_bit(1'b0);
        ones_run = 0;
    endtask

    task automatic send_sbit(input logic b);
        put_bit(b);
        if (b) ones_run++; else ones_run = 0;
        if (ones_run == 5) begin
            put_bit(1'b0);
            ones_run = 0;
        end
    endtask

    task automatic crc_bit(input logic b);
        crc = (crc >> 1) ^ ((crc[0] ^ b) ? 16'h8408 : 16'h0000);
    endtask

    task automatic send_byte(input logic [7:0] v, input int gap);
        for (int i = 0; i < 8; i++) begin
            crc_bit(v[i]);
            send_sbit(v[i]);
        end
        if (gap > 0) idle(gap);
    endtask

    task automatic send_fcs(input bit flip);
        logic [15:0] f;
        f = ~crc;
        if (flip) f[15] = ~f[15];
        for (int i = 0; i < 16; i++) send_sbit(f[i]);
    endtask

    task automatic begin_frame();
        crc = 16'hFFFF;
        send_flag();
    endtask

    task automatic send_frame(input int n, input int gap);
        for (int i = 0; i < n; i++) send_byte(exp_b[i], gap);
        send_fcs(1'b0);
    endtask

    task automatic check_bytes(input int base, input int n, input string req);
        check(ngot - base == n, req, ngot - base, n);
        for (int i = 0; i < n; i++)
            check(got[base + i] == exp_b[i], req, got[base + i], exp_b[i]);
    endtask

    task automatic t_reset();
        check(!out_valid && !frame_active && !frame_err && !frame_done && !frame_abort,
              "R10 reset", {out_valid, frame_active, frame_err, frame_done, frame_abort}, 0);
    endtask

    task automatic t_idle_flags();
        int a0 = n_active;
        int d0 = n_done;
        for (int i = 0; i < 5; i++) send_flag();
        idle(4);
        check(n_active == a0, "R1 idle flags active", n_active - a0, 0);
        check(n_done == d0, "R1 idle flags done", n_done - d0, 0);
    endtask

    task automatic t_good_frame();
        int b0 = ngot;
        int d0 = n_done;
        int e0 = n_err_rise;
        exp_b[0] = 8'h11; exp_b[1] = 8'hA5; exp_b[2] = 8'h3C; exp_b[3] = 8'h80;
        begin_frame();
        send_frame(4, 0);
        send_flag();
        idle(6);
        check_bytes(b0, 4, "R4 bytes");
        check(n_done - d0 == 1, "R5 done pulse", n_done - d0, 1);
        check(n_err_rise == e0, "R5 no error", n_err_rise - e0, 0);
    endtask

    task automatic t_stuffing();
        int b0 = ngot;
        int d0 = n_done;
        exp_b[0] = 8'hFF; exp_b[1] = 8'h7E; exp_b[2] = 8'h3F; exp_b[3] = 8'hFC; exp_b[4] = 8'hF8;
        begin_frame();
        send_frame(5, 0);
        send_flag();
        idle(6);
        check_bytes(b0, 5, "R2 destuffed bytes");
        check(n_done - d0 == 1, "R2 done", n_done - d0, 1);
    endtask

    task automatic t_shared_flag();
        int b0 = ngot;
        int d0 = n_done;
        exp_b[0] = 8'h5A; exp_b[1] = 8'hC3;
        begin_frame();
        send_frame(2, 0);
        begin_frame();
        send_frame(2, 0);
        send_flag();
        idle(6);
        check(ngot - b0 == 4, "R1 shared flag bytes", ngot - b0, 4);
        check(n_done - d0 == 2, "R1 shared flag frames", n_done - d0, 2);
    endtask

    task automatic t_bad_fcs();
        int d0 = n_done;
        int e0 = n_err_rise;
        exp_b[0] = 8'h01; exp_b[1] = 8'h02; exp_b[2] = 8'h03;
        begin_frame();
        for (int i = 0; i < 3; i++) send_byte(exp_b[i], 0);
        send_fcs(1'b1);
        send_flag();
        idle(6);
        check(n_err_rise - e0 == 1, "R7 fcs error", n_err_rise - e0, 1);
        check(n_done == d0, "R7 no done", n_done - d0, 0);
    endtask

    task automatic t_misaligned();
        int d0 = n_done;
        int e0 = n_err_rise;
        begin_frame();
        send_byte(8'h44, 0);
        send_byte(8'h99, 0);
        crc_bit(1'b1); send_sbit(1'b1);
        crc_bit(1'b0); send_sbit(1'b0);
        crc_bit(1'b1); send_sbit(1'b1);
        send_fcs(1'b0);
        send_flag();
        idle(6);
        check(n_err_rise - e0 == 1, "R6 misaligned error", n_err_rise - e0, 1);
        check(n_done == d0, "R6 no done", n_done - d0, 0);
    endtask

    task automatic t_abort();
        int d0 = n_done;
        int e0 = n_err_rise;
        int ab0 = n_abort;
        int a1;
        begin_frame();
        send_byte(8'h12, 0);
        send_byte(8'h34, 0);
        send_byte(8'h56, 0);
        for (int i = 0; i < 7; i++) put_bit(1'b1);
        idle(4);
        check(n_abort - ab0 == 1, "R3 abort pulse", n_abort - ab0, 1);
        check(n_done == d0 && n_err_rise == e0, "R3 no done/err", n_done - d0 + n_err_rise - e0, 0);
        check(!out_valid, "R3 byte withdrawn", out_valid, 0);
        a1 = n_active;
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 8; i++) put_bit(i[0]);
        idle(4);
        check(n_active == a1, "R3 ignored until flag", n_active - a1, 0);
        exp_b[0] = 8'hA0; exp_b[1] = 8'h0B;
        begin_frame();
        send_frame(2, 0);
        send_flag();
        idle(6);
        check(n_done - d0 == 1, "R3 recovery frame", n_done - d0, 1);
    endtask

    task automatic t_rx_en_gaps();
        int b0 = ngot;
        int d0 = n_done;
        exp_b[0] = 8'hE7; exp_b[1] = 8'h18; exp_b[2] = 8'hFF;
        begin_frame();
        send_frame(3, 9);
        idle(9);
        send_flag();
        idle(6);
        check_bytes(b0, 3, "R9 gaps bytes");
        check(n_done - d0 == 1, "R9 gaps done", n_done - d0, 1);
    endtask

    task automatic t_slow_backend();
        int b0 = ngot;
        int d0 = n_done;
        int e0 = n_err_rise;
        take_en = 1'b0;
        begin_frame();
        for (int i = 0; i < 4; i++) send_byte(8'h20 + 8'(i), 0);
        send_fcs(1'b0);
        @(negedge clk);
        check(frame_err && frame_active, "R8 error held in frame", {frame_err, frame_active}, 3);
        send_flag();
        idle(6);
        check(n_err_rise - e0 == 1, "R8 single error", n_err_rise - e0, 1);
        check(n_done == d0, "R8 no done", n_done - d0, 0);
        check(!frame_active && !frame_err, "R8 released at flag", {frame_active, frame_err}, 0);
        take_en = 1'b1;
        idle(2);
        check(ngot == b0, "R8 nothing taken", ngot - b0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_flags();
        t_good_frame();
        t_stuffing();
        t_shared_flag();
        t_bad_fcs();
        t_misaligned();
        t_abort();
        t_rx_en_gaps();
        t_slow_backend();
        check(n_bad_err == 0, "R10 err only in frame", n_bad_err, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule